// File: doc/BRIEF.md
# Configuration Channel Transaction Controller

This block lets software reach a small bank of oscillator setting words through four memory-mapped registers. Software first places a value in the outgoing data register, then writes the control register with a device index, a function code, a direction bit and a start bit. That control write clears the status register. When the start bit is set, the block performs the access on the following clock: a write copies the outgoing data into the chosen oscillator entry, and a read copies the chosen entry into the returned-data register. The status register then shows done, and also error when the target was not legal.

The oscillator bank is internal. Its number of entries and its reset contents are parameters. Reads of the register port are combinational on the address. Writes take effect at the clock edge on which the write strobe is high.

Top module: `cfg_xfer_ctrl`

## Requirements
- R1: After reset, the control register reads 0x00100000 and the status, outgoing data and returned-data registers read 0. Oscillator entry i holds bits [32*i+31:32*i] of the OSC_INIT parameter.
- R2: The register offsets are returned data 0xA0, outgoing data 0xA4, control 0xA8 and status 0xAC. Any other offset reads 0, and a write to any other offset changes no register.
- R3: Control fields are device index [11:0], function [25:20], write direction [30] and start [31]. Bits [19:12], bits [29:26] and the start bit always read back as 0.
- R4: Any write to the control register clears status, so status reads 0 in the cycle after the write.
- R5: A control write with start=1 completes one cycle after the write. From then on, status bit 0 (done) reads 1.
- R6: A completed legal transfer with the direction bit set copies the outgoing data register into oscillator entry [device index].
- R7: A completed legal transfer with the direction bit clear loads oscillator entry [device index] into the returned-data register.
- R8: A transfer is illegal when its function code is not 1 or its device index is NUM_OSC or greater. An illegal transfer sets status bit 1 (error) together with done, and leaves the bank and the returned-data register unchanged.
- R9: A control write with start=0 only stores the control fields. Status stays 0, and neither the bank nor the returned-data register changes.
- R10: The outgoing data register reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |

## Verification
Assertions check several properties on every cycle. A control write always leaves status clear on the next cycle. Reserved and start bits never survive in the stored control word. A launched transfer always yields done, with error exactly when the target check rejected it. An oscillator entry or the returned-data register only moves on a legal transfer of the matching direction. Only the bench scenarios can show that the right entry receives the right data, that values survive a write followed by a read through the channel, and that the reset contents and the boundary device index NUM_OSC-1 are handled correctly when observed through the register port.

// File: rtl/cfgch_pkg.sv
// Package: shared constants and field positions for the configuration
// channel controller. Assumes a 32-bit data path and 12-bit byte offsets.
package cfgch_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;
    localparam int DEV_W  = 12;
    localparam int FUNC_W = 6;

    localparam logic [ADDR_W-1:0] OFS_RTN  = 12'h0A0;
    localparam logic [ADDR_W-1:0] OFS_OUT  = 12'h0A4;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 12'h0A8;
    localparam logic [ADDR_W-1:0] OFS_STAT = 12'h0AC;

    localparam int DEV_LSB  = 0;
    localparam int FUNC_LSB = 20;
    localparam int DIR_BIT  = 30;
    localparam int GO_BIT   = 31;

    // Bits of the control word that are kept when it is stored.
    localparam logic [DATA_W-1:0] CTRL_KEEP = 32'h43F0_0FFF;
    localparam logic [DATA_W-1:0] CTRL_RST  = 32'h0010_0000;
    localparam logic [FUNC_W-1:0] FUNC_OSC  = 6'd1;
endpackage

// File: rtl/cfgch_target_chk.sv
// Target check: decides whether the stored function/device pair names an
// existing oscillator entry and produces the bank index.
// Assumes NUM_OSC is between 1 and 16.
module cfgch_target_chk
    import cfgch_pkg::*;
#(
    parameter int NUM_OSC = 4,
    parameter int IDX_W   = 2
) (
    input  logic [FUNC_W-1:0] func,
    input  logic [DEV_W-1:0]  dev,
    output logic              tgt_ok,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [DEV_W-1:0] DEV_LIMIT = DEV_W'(NUM_OSC);

    // Legal only for the oscillator function and an index inside the bank.
    always_comb begin
        tgt_ok = (func == FUNC_OSC) && (dev < DEV_LIMIT);
        idx    = dev[IDX_W-1:0];
    end

    // R8: an accepted target must address an existing entry.
    always_comb begin
        if (tgt_ok) begin
            assert_idx_in_range_R8: assert (int'(idx) < NUM_OSC);
        end
    end
endmodule

// File: rtl/cfgch_osc_bank.sv
// Oscillator bank: NUM_OSC 32-bit entries that reload from OSC_INIT on reset.
// One entry is written per cycle, and the read port is combinational.
module cfgch_osc_bank
    import cfgch_pkg::*;
#(
    parameter int                      NUM_OSC  = 4,
    parameter int                      IDX_W    = 2,
    parameter logic [NUM_OSC*32-1:0]   OSC_INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] ent [NUM_OSC];

    for (genvar g = 0; g < NUM_OSC; g++) begin : g_ent
        // One register per entry, loaded on reset or on its own write select.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent[g] <= OSC_INIT[g*32 +: 32];
            else if (we && idx == IDX_W'(g))
                ent[g] <= wdata;
        end

        // R6/R8: an entry changes only on a write that selects it.
        assert_entry_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && idx == IDX_W'(g)) |=> $stable(ent[g]));
    end

    // Read mux over the existing entries only; out-of-range indices return 0.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_OSC; i++) begin
            if (idx == IDX_W'(i)) rdata = ent[i];
        end
    end
endmodule

// File: rtl/cfgch_regs.sv
// Register file and transfer sequencer: holds the control, status, outgoing
// and returned-data registers. It launches a transfer the cycle after a control
// write with start set and finishes it on the next edge.
// Assumes the target check and the bank read are combinational.
module cfgch_regs
    import cfgch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              tgt_ok,
    input  logic [DATA_W-1:0] bank_rdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              bank_we,
    output logic [DATA_W-1:0] bank_wdata
);
    logic [DATA_W-1:0] out_q, rtn_q;
    logic              done_q, err_q, launch_q;
    logic              wr_ctrl, wr_out, rd_fetch;

    // Write decode for the two writable registers.
    always_comb begin
        wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
        wr_out  = reg_wr && (reg_addr == OFS_OUT);
    end

    // Completion actions of a launched transfer.
    always_comb begin
        bank_we    = launch_q && tgt_ok && ctrl_q[DIR_BIT];
        rd_fetch   = launch_q && tgt_ok && !ctrl_q[DIR_BIT];
        bank_wdata = out_q;
    end

    // Control store: masks off reserved and start bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= CTRL_RST;
        else if (wr_ctrl) ctrl_q <= reg_wdata & CTRL_KEEP;
    end

    // Launch flag: one cycle after a control write carrying start.
    always_ff @(posedge clk) begin
        if (!rst_n) launch_q <= 1'b0;
        else        launch_q <= wr_ctrl && reg_wdata[GO_BIT];
    end

    // Outgoing data register.
    always_ff @(posedge clk) begin
        if (!rst_n)      out_q <= '0;
        else if (wr_out) out_q <= reg_wdata;
    end

    // Returned-data register: loaded only by a legal read transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)        rtn_q <= '0;
        else if (rd_fetch) rtn_q <= bank_rdata;
    end

    // Status: a control write clears it and a completion sets done/error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else if (wr_ctrl) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else if (launch_q) begin
            done_q <= 1'b1;
            err_q  <= !tgt_ok;
        end
    end

    // Combinational read mux; unmapped offsets return zero.
    always_comb begin
        case (reg_addr)
            OFS_RTN:  reg_rdata = rtn_q;
            OFS_OUT:  reg_rdata = out_q;
            OFS_CTRL: reg_rdata = ctrl_q;
            OFS_STAT: reg_rdata = {30'd0, err_q, done_q};
            default:  reg_rdata = '0;
        endcase
    end

    assert_ctrl_clears_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (!done_q && !err_q));

    assert_ctrl_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> ((ctrl_q & ~CTRL_KEEP) == '0));

    assert_launch_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_q && !wr_ctrl) |=> done_q);

    assert_illegal_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_q && !wr_ctrl) |=> (err_q == $past(!tgt_ok)));

    assert_rtn_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_fetch |=> $stable(rtn_q));

    assert_err_implies_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> done_q);
endmodule

// File: rtl/cfg_xfer_ctrl.sv
// Top level: configuration channel controller. It connects the register file,
// the target check and the oscillator bank.
// Assumes 1 <= NUM_OSC <= 16, with OSC_INIT holding entry i at bits [32i+31:32i].
module cfg_xfer_ctrl
    import cfgch_pkg::*;
#(
    parameter int                    NUM_OSC  = 4,
    parameter logic [NUM_OSC*32-1:0] OSC_INIT = {32'h0165_A0BC, 32'h02FA_F080,
                                                 32'h017D_7840, 32'h0262_5A00}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);
    localparam int IDX_W = (NUM_OSC > 1) ? $clog2(NUM_OSC) : 1;

    logic [DATA_W-1:0] ctrl_q, bank_rdata, bank_wdata;
    logic              tgt_ok, bank_we;
    logic [IDX_W-1:0]  idx;

    cfgch_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .tgt_ok     (tgt_ok),
        .bank_rdata (bank_rdata),
        .ctrl_q     (ctrl_q),
        .bank_we    (bank_we),
        .bank_wdata (bank_wdata)
    );

    cfgch_target_chk #(.NUM_OSC(NUM_OSC), .IDX_W(IDX_W)) u_chk (
        .func   (ctrl_q[FUNC_LSB +: FUNC_W]),
        .dev    (ctrl_q[DEV_LSB +: DEV_W]),
        .tgt_ok (tgt_ok),
        .idx    (idx)
    );

    cfgch_osc_bank #(.NUM_OSC(NUM_OSC), .IDX_W(IDX_W), .OSC_INIT(OSC_INIT)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bank_we),
        .idx   (idx),
        .wdata (bank_wdata),
        .rdata (bank_rdata)
    );
endmodule

// File: tb/test_cfg_xfer_ctrl.sv
`timescale 1ns/1ps
module test_cfg_xfer_ctrl;
    localparam int NOSC = 4;
    localparam logic [NOSC*32-1:0] INIT = {32'h0165_A0BC, 32'h02FA_F080,
                                           32'h017D_7840, 32'h0262_5A00};
    localparam logic [11:0] A_RTN = 12'h0A0, A_OUT = 12'h0A4,
                            A_CTL = 12'h0A8, A_STA = 12'h0AC;
    localparam logic [31:0] GO = 32'h8000_0000, DIRW = 32'h4000_0000,
                            F1 = 32'h0010_0000;

    logic clk = 0, rst_n = 0, reg_wr = 0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    int checks = 0, errors = 0;

    cfg_xfer_ctrl #(.NUM_OSC(NOSC), .OSC_INIT(INIT)) i_cfg_xfer_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; #2;
        d = reg_rdata;
    endtask

    task automatic expect_reg(input string req, input logic [11:0] a, input logic [31:0] e);
        logic [31:0] d;
        rd(a, d);
        check(req, d, e);
    endtask

    // Launch a transfer, confirm status cleared first (R4), return final status.
    task automatic xfer(input logic [31:0] ctl, output logic [31:0] st);
        logic [31:0] d;
        wr(A_CTL, ctl);
        rd(A_STA, d);
        check("R4 status cleared after control write", d, 32'h0);
        @(posedge clk);
        rd(A_STA, st);
    endtask

    task automatic t_reset;
        expect_reg("R1 control reset", A_CTL, 32'h0010_0000);
        expect_reg("R1 status reset", A_STA, 32'h0);
        expect_reg("R1 outgoing reset", A_OUT, 32'h0);
        expect_reg("R1 returned reset", A_RTN, 32'h0);
    endtask

    task automatic t_read_all;
        logic [31:0] st;
        for (int i = 0; i < NOSC; i++) begin
            xfer(GO | F1 | 32'(i), st);
            check("R5 done after read", st, 32'h1);
            expect_reg("R7 R1 entry reset value via read", A_RTN, INIT[i*32 +: 32]);
        end
    endtask

    task automatic t_map;
        wr(A_OUT, 32'hCAFE_F00D);
        expect_reg("R10 outgoing readback", A_OUT, 32'hCAFE_F00D);
        expect_reg("R2 unmapped offset reads 0", 12'h0B0, 32'h0);
        wr(12'h0B0, 32'h1234_5678);
        wr(12'h000, 32'hFFFF_FFFF);
        expect_reg("R2 stray write leaves outgoing", A_OUT, 32'hCAFE_F00D);
        expect_reg("R2 stray write leaves control", A_CTL, 32'h0010_0003);
    endtask

    task automatic t_write_then_read;
        logic [31:0] st;
        wr(A_OUT, 32'hA5A5_0002);
        xfer(GO | DIRW | F1 | 32'd2, st);
        check("R5 done after write", st, 32'h1);
        wr(A_OUT, 32'hBEEF_0003);
        xfer(GO | DIRW | F1 | 32'd3, st);
        check("R6 boundary device write done", st, 32'h1);
        xfer(GO | F1 | 32'd2, st);
        expect_reg("R6 entry 2 written", A_RTN, 32'hA5A5_0002);
        xfer(GO | F1 | 32'd3, st);
        expect_reg("R6 entry 3 written", A_RTN, 32'hBEEF_0003);
        xfer(GO | F1 | 32'd1, st);
        expect_reg("R6 entry 1 untouched", A_RTN, INIT[32 +: 32]);
    endtask

    task automatic t_illegal;
        logic [31:0] st;
        xfer(32'hFFFF_FFFF, st);
        check("R8 bad function flags error", st, 32'h3);
        expect_reg("R3 reserved and start stored as 0", A_CTL, 32'h43F0_0FFF);
        expect_reg("R8 returned data unchanged", A_RTN, INIT[32 +: 32]);
        wr(A_OUT, 32'h0BAD_0BAD);
        xfer(GO | DIRW | 32'h0020_0000 | 32'd1, st);
        check("R8 function 2 write error", st, 32'h3);
        xfer(GO | DIRW | F1 | 32'd4, st);
        check("R8 device == NUM_OSC error", st, 32'h3);
        xfer(GO | F1 | 32'd4, st);
        check("R8 read of device NUM_OSC error", st, 32'h3);
        expect_reg("R8 returned data kept on bad read", A_RTN, INIT[32 +: 32]);
        xfer(GO | F1 | 32'd0, st);
        expect_reg("R8 entry 0 untouched by bad writes", A_RTN, INIT[31:0]);
    endtask

    task automatic t_no_start;
        logic [31:0] st;
        xfer(GO | F1 | 32'd1, st);
        check("R5 done before no-start write", st, 32'h1);
        wr(A_OUT, 32'h7777_7777);
        xfer(DIRW | F1 | 32'd1, st);
        check("R9 no start leaves status 0", st, 32'h0);
        expect_reg("R9 control fields stored", A_CTL, DIRW | F1 | 32'd1);
        expect_reg("R9 returned data unchanged", A_RTN, INIT[32 +: 32]);
        xfer(GO | F1 | 32'd1, st);
        expect_reg("R9 entry 1 not written without start", A_RTN, INIT[32 +: 32]);
    endtask

    initial begin
        #(200000 * 20);
        errors++; checks++;
        $display("FAIL watchdog all actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_read_all();
        t_map();
        t_write_then_read();
        t_illegal();
        t_no_start();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule